// File: doc/BRIEF.md
# Mixed-Width Register Access Adapter

This block sits between a processor-side request port and a 512-byte register space. The processor issues byte, word or long accesses. Each register in the space has a fixed native width of one, two or four bytes, and all registers in one aligned 4-byte group share that width. The adapter turns each request into the sequence of native-width accesses that the register space accepts. A wide request over narrow registers is split into several accesses. A narrow request into a wide register becomes one read, plus a write-back of the merged value when the request is a write. Byte order is big-endian throughout: the lowest offset always carries the most significant part.

The request port uses a valid/ready handshake. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high only while the adapter is idle, so a requester stalls by holding its request and `req_valid` until the adapter accepts it. There is no back-pressure on responses. `rsp_valid` is a one-cycle strobe that the requester must take when it appears, and it comes only after every sub-access of the request has finished. On the register side the adapter issues at most one access per clock. Read data must be presented on `reg_rdata` in the cycle after the read is issued.

Top module: `mwa_adapter`

## Requirements
- R1: Only the low 10 bits of `req_addr` form the offset. All higher address bits are ignored.
- R2: A request whose 10-bit offset is 0x200 or above, or whose `req_size` is 3, ends with `rsp_err`=1 and `rsp_rdata`=0 in the first cycle after acceptance. It makes no register-side access.
- R3: The native width of an offset is chosen by offset bits [7:6]: 00 gives one byte, 01 gives two bytes, 10 gives four bytes, and 11 (unassigned) is handled as one byte. `req_size` and `reg_size` use the codes 0 = byte, 1 = word and 2 = long. Every sub-access uses the native size code. Offset bits below the request size are ignored, and every sub-access address is aligned to its size.
- R4: A request whose size equals the native width makes one register access at the aligned offset. Data is right-justified on all data buses.
- R5: A request wider than the native width is split into native-width accesses at ascending offsets. The first access carries the most significant part. A long over word registers makes two accesses, and a long over byte registers makes four.
- R6: A read narrower than the native width makes one read of the aligned native register. It returns the addressed lane, and a lower offset selects a more significant lane.
- R7: A write narrower than the native width reads the aligned native register, then writes the whole register back with only the addressed lane replaced. This is exactly one read followed by one write.
- R8: Sub-accesses go out one per cycle. Counting cycle 1 as the first cycle after the accepting edge, `rsp_valid` rises in cycle N+1 for an N-access write, N+2 for an N-access read, 3 for a narrow read and 4 for a narrow write.
- R9: `req_ready` is high only while idle, and the adapter makes no register access while idle. `rsp_valid` is high for exactly one cycle, and `req_ready` returns in the next cycle. A write returns zero data.
- R10: While reset is asserted, `req_ready` is 1 and `rsp_valid` and `reg_en` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Adapter idle and able to accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | Request size code (0 byte, 1 word, 2 long) |
| req_addr | input | ADDR_W | Request address; only the low 10 bits are used |
| req_wdata | input | 32 | Write data, right-justified |
| rsp_valid | output | 1 | One-cycle completion strobe |
| rsp_err | output | 1 | Request rejected (out of range or illegal size) |
| rsp_rdata | output | 32 | Read data, right-justified |
| reg_en | output | 1 | Register-side access strobe |
| reg_we | output | 1 | Register-side write enable |
| reg_size | output | 2 | Native size code of the access |
| reg_addr | output | 9 | Register offset of the access |
| reg_wdata | output | 32 | Register write data, right-justified |
| reg_rdata | input | 32 | Register read data, valid the cycle after a read |

## Verification
Each result has a fixed due cycle, counted from the accepting edge. An error response is due in cycle 1. A write split into N accesses answers in cycle N+1, a read split into N accesses in cycle N+2, a narrow read in cycle 3 and a narrow write in cycle 4. The bench holds the expected cycle in its vector table and counts cycles at falling edges from acceptance until `rsp_valid` rises, comparing that count with the table. Access counts, write counts and native sizes are tallied at rising edges by the register model and compared once the strobe is seen, when every sub-access has already landed. `req_ready` and the strobe's one-cycle width are checked in cycle 1 and in the cycle after the strobe.

// File: rtl/mwa_pkg.sv
package mwa_pkg;

  localparam int DATA_W = 32;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_WORD = 2'd1,
    SZ_LONG = 2'd2,
    SZ_NONE = 2'd3
  } sz_e;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_BEAT  = 3'd1,
    ST_DRAIN = 3'd2,
    ST_WBACK = 3'd3,
    ST_DONE  = 3'd4
  } st_e;

  // Native width of a 4-byte group, chosen by group index bits [5:4]
  // (offset bits [7:6]); code 3 marks an unassigned group.
  function automatic logic [1:0] group_width(input int unsigned g);
    logic [31:0] gv;
    gv = g;
    case (gv[5:4])
      2'b00:   return SZ_BYTE;
      2'b01:   return SZ_WORD;
      2'b10:   return SZ_LONG;
      default: return SZ_NONE;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] lane_mask(input logic [1:0] code);
    case (code)
      2'd0:    return DATA_W'(32'h0000_00FF);
      2'd1:    return DATA_W'(32'h0000_FFFF);
      default: return DATA_W'(32'hFFFF_FFFF);
    endcase
  endfunction

endpackage

// File: rtl/mwa_width_rom.sv
module mwa_width_rom #(
  parameter  int GROUPS = 128,
  localparam int GI_W   = $clog2(GROUPS)
) (
  input  logic [GI_W-1:0] group_i,
  output logic [1:0]      width_o
);

  logic [1:0] tbl [GROUPS];

  for (genvar g = 0; g < GROUPS; g++) begin : g_ent
    assign tbl[g] = mwa_pkg::group_width(g);
  end

  assign width_o = tbl[group_i];

endmodule

// File: rtl/mwa_planner.sv
module mwa_planner
  import mwa_pkg::*;
#(
  parameter  int OFF_W = 10,
  localparam int RA_W  = OFF_W - 1
) (
  input  logic [OFF_W-1:0] addr_off,
  input  logic [1:0]       size_i,
  input  logic [1:0]       native_i,
  output logic             err_o,
  output logic [RA_W-1:0]  base_o,
  output logic [1:0]       beat_o,
  output logic [1:0]       last_o,
  output logic             narrow_o,
  output logic [5:0]       shamt_o
);

  logic [1:0]      eff;
  logic [RA_W-1:0] off;
  logic [RA_W-1:0] a_off;
  int              sb;
  int              wb;
  int              k;

  always_comb begin
    eff   = (native_i == SZ_NONE) ? SZ_BYTE : native_i;
    off   = addr_off[RA_W-1:0];
    err_o = addr_off[OFF_W-1] || (size_i == SZ_NONE);
    sb    = 1 << size_i;
    wb    = 1 << eff;
    a_off = off & ~RA_W'(sb - 1);
    beat_o = eff;
    k      = 0;
    if (size_i >= eff) begin
      // same width or split: beats of native width from the aligned offset
      base_o   = a_off;
      last_o   = 2'((1 << (size_i - eff)) - 1);
      narrow_o = 1'b0;
      shamt_o  = 6'd0;
    end else begin
      // narrow: one native access, lane picked big-endian
      base_o   = off & ~RA_W'(wb - 1);
      k        = int'(a_off) & (wb - 1);
      last_o   = 2'd0;
      narrow_o = 1'b1;
      shamt_o  = 6'(8 * (wb - k - sb));
    end
  end

endmodule

// File: rtl/mwa_lane.sv
module mwa_lane
  import mwa_pkg::*;
(
  input  logic [DATA_W-1:0] native_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [1:0]        size_i,
  input  logic [5:0]        shamt_i,
  output logic [DATA_W-1:0] lane_o,
  output logic [DATA_W-1:0] merged_o
);

  logic [DATA_W-1:0] m;

  always_comb begin
    m        = lane_mask(size_i);
    lane_o   = (native_i >> shamt_i) & m;
    merged_o = (native_i & ~(m << shamt_i)) | ((wdata_i & m) << shamt_i);
  end

endmodule

// File: rtl/mwa_seq.sv
module mwa_seq
  import mwa_pkg::*;
#(
  parameter int RA_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [1:0]        req_size,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              plan_err,
  input  logic [RA_W-1:0]   plan_base,
  input  logic [1:0]        plan_beat,
  input  logic [1:0]        plan_last,
  input  logic              plan_narrow,
  input  logic [5:0]        plan_shamt,
  output logic              rsp_valid,
  output logic              rsp_err,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              reg_en,
  output logic              reg_we,
  output logic [1:0]        reg_size,
  output logic [RA_W-1:0]   reg_addr,
  output logic [DATA_W-1:0] reg_wdata,
  input  logic [DATA_W-1:0] reg_rdata,
  output logic [DATA_W-1:0] acc_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic [1:0]        size_o,
  output logic [5:0]        shamt_o,
  input  logic [DATA_W-1:0] lane_rd_i,
  input  logic [DATA_W-1:0] lane_merged_i
);

  st_e               st_q;
  logic [RA_W-1:0]   base_q;
  logic [1:0]        beat_q;
  logic [1:0]        last_q;
  logic [1:0]        idx_q;
  logic              write_q;
  logic              narrow_q;
  logic              err_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] acc_q;
  logic [1:0]        size_q;
  logic [5:0]        shamt_q;
  logic              rd_pend_q;

  logic [5:0]        beat_bits;
  logic [5:0]        slice_sh;
  logic              last_beat;

  assign acc_o   = acc_q;
  assign wdata_o = wdata_q;
  assign size_o  = size_q;
  assign shamt_o = shamt_q;

  always_comb begin
    beat_bits = 6'd8 << beat_q;
    slice_sh  = 6'(int'(beat_bits) * int'(last_q - idx_q));
    last_beat = (idx_q == last_q);
    req_ready = (st_q == ST_IDLE);

    reg_en    = 1'b0;
    reg_we    = 1'b0;
    reg_size  = beat_q;
    reg_addr  = base_q;
    reg_wdata = '0;
    case (st_q)
      ST_BEAT: begin
        reg_en    = 1'b1;
        reg_we    = write_q && !narrow_q;
        reg_addr  = base_q + (RA_W'(idx_q) << beat_q);
        reg_wdata = reg_we ? ((wdata_q >> slice_sh) & lane_mask(beat_q)) : '0;
      end
      ST_WBACK: begin
        reg_en    = 1'b1;
        reg_we    = 1'b1;
        reg_wdata = lane_merged_i;
      end
      default: ;
    endcase

    rsp_valid = (st_q == ST_DONE);
    rsp_err   = rsp_valid && err_q;
    if (rsp_valid && !write_q && !err_q)
      rsp_rdata = narrow_q ? lane_rd_i : acc_q;
    else
      rsp_rdata = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      base_q    <= '0;
      beat_q    <= '0;
      last_q    <= '0;
      idx_q     <= '0;
      write_q   <= 1'b0;
      narrow_q  <= 1'b0;
      err_q     <= 1'b0;
      wdata_q   <= '0;
      acc_q     <= '0;
      size_q    <= '0;
      shamt_q   <= '0;
      rd_pend_q <= 1'b0;
    end else begin
      rd_pend_q <= reg_en && !reg_we;
      if (rd_pend_q)
        acc_q <= (acc_q << beat_bits) | (reg_rdata & lane_mask(beat_q));
      case (st_q)
        ST_IDLE: begin
          if (req_valid) begin
            write_q  <= req_write;
            size_q   <= req_size;
            wdata_q  <= req_wdata;
            base_q   <= plan_base;
            beat_q   <= plan_beat;
            last_q   <= plan_last;
            narrow_q <= plan_narrow;
            shamt_q  <= plan_shamt;
            err_q    <= plan_err;
            idx_q    <= '0;
            acc_q    <= '0;
            st_q     <= plan_err ? ST_DONE : ST_BEAT;
          end
        end
        ST_BEAT: begin
          if (last_beat)
            st_q <= (write_q && !narrow_q) ? ST_DONE : ST_DRAIN;
          else
            idx_q <= idx_q + 2'd1;
        end
        ST_DRAIN: st_q <= (write_q && narrow_q) ? ST_WBACK : ST_DONE;
        ST_WBACK: st_q <= ST_DONE;
        default:  st_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/mwa_adapter.sv
module mwa_adapter
  import mwa_pkg::*;
#(
  parameter  int ADDR_W = 32,
  parameter  int OFF_W  = 10,
  localparam int RA_W   = OFF_W - 1,
  localparam int GROUPS = (1 << RA_W) / 4,
  localparam int GI_W   = $clog2(GROUPS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [1:0]        req_size,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic              rsp_err,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              reg_en,
  output logic              reg_we,
  output logic [1:0]        reg_size,
  output logic [RA_W-1:0]   reg_addr,
  output logic [DATA_W-1:0] reg_wdata,
  input  logic [DATA_W-1:0] reg_rdata
);

  logic [OFF_W-1:0]  off;
  logic [1:0]        native;
  logic              p_err;
  logic [RA_W-1:0]   p_base;
  logic [1:0]        p_beat;
  logic [1:0]        p_last;
  logic              p_narrow;
  logic [5:0]        p_shamt;
  logic [DATA_W-1:0] l_acc;
  logic [DATA_W-1:0] l_wdata;
  logic [1:0]        l_size;
  logic [5:0]        l_shamt;
  logic [DATA_W-1:0] l_rd;
  logic [DATA_W-1:0] l_merged;
  logic              unused_addr_hi;

  assign off            = req_addr[OFF_W-1:0];
  assign unused_addr_hi = ^req_addr[ADDR_W-1:OFF_W];

  mwa_width_rom #(.GROUPS(GROUPS)) u_rom (
    .group_i (off[RA_W-1:2]),
    .width_o (native)
  );

  mwa_planner #(.OFF_W(OFF_W)) u_plan (
    .addr_off (off),
    .size_i   (req_size),
    .native_i (native),
    .err_o    (p_err),
    .base_o   (p_base),
    .beat_o   (p_beat),
    .last_o   (p_last),
    .narrow_o (p_narrow),
    .shamt_o  (p_shamt)
  );

  mwa_seq #(.RA_W(RA_W)) u_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_write     (req_write),
    .req_size      (req_size),
    .req_wdata     (req_wdata),
    .plan_err      (p_err),
    .plan_base     (p_base),
    .plan_beat     (p_beat),
    .plan_last     (p_last),
    .plan_narrow   (p_narrow),
    .plan_shamt    (p_shamt),
    .rsp_valid     (rsp_valid),
    .rsp_err       (rsp_err),
    .rsp_rdata     (rsp_rdata),
    .reg_en        (reg_en),
    .reg_we        (reg_we),
    .reg_size      (reg_size),
    .reg_addr      (reg_addr),
    .reg_wdata     (reg_wdata),
    .reg_rdata     (reg_rdata),
    .acc_o         (l_acc),
    .wdata_o       (l_wdata),
    .size_o        (l_size),
    .shamt_o       (l_shamt),
    .lane_rd_i     (l_rd),
    .lane_merged_i (l_merged)
  );

  mwa_lane u_lane (
    .native_i (l_acc),
    .wdata_i  (l_wdata),
    .size_i   (l_size),
    .shamt_i  (l_shamt),
    .lane_o   (l_rd),
    .merged_o (l_merged)
  );

endmodule

// File: rtl/mwa_adapter_chk.sv
module mwa_adapter_chk #(
  parameter int RA_W = 9
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            req_ready,
  input logic            rsp_valid,
  input logic            rsp_err,
  input logic [31:0]     rsp_rdata,
  input logic            reg_en,
  input logic [1:0]      reg_size,
  input logic [RA_W-1:0] reg_addr
);

  AST_ERR_NO_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_err) |-> !$past(reg_en)); // R2

  AST_ERR_ZERO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_err) |-> (rsp_rdata == 32'd0)); // R2

  AST_SUB_SIZE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    reg_en |-> (reg_size != 2'd3)); // R3

  AST_SUB_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    reg_en |-> ((reg_addr & ((RA_W'(1) << reg_size) - RA_W'(1))) == '0)); // R3

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid); // R9

  AST_READY_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> req_ready); // R9

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!reg_en && !rsp_valid)); // R9

  AST_ACCEPT_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready); // R9

endmodule

bind mwa_adapter mwa_adapter_chk #(.RA_W(RA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .rsp_err   (rsp_err),
  .rsp_rdata (rsp_rdata),
  .reg_en    (reg_en),
  .reg_size  (reg_size),
  .reg_addr  (reg_addr)
);

// File: tb/mwa_adapter_tb.sv
module mwa_adapter_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [1:0]  req_size = 2'd0;
  logic [31:0] req_addr = 32'd0;
  logic [31:0] req_wdata = 32'd0;
  logic        rsp_valid;
  logic        rsp_err;
  logic [31:0] rsp_rdata;
  logic        reg_en;
  logic        reg_we;
  logic [1:0]  reg_size;
  logic [8:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata = 32'd0;

  int n_chk = 0;
  int n_fail = 0;
  int n_acc = 0;
  int n_wr = 0;
  int n_szbad = 0;
  logic [1:0] exp_nat = 2'd0;
  logic [7:0] dm [512];
  logic [7:0] rm [512];

  always #10 clk = ~clk;

  mwa_adapter u_dut (
    .clk (clk), .rst_n (rst_n),
    .req_valid (req_valid), .req_ready (req_ready), .req_write (req_write),
    .req_size (req_size), .req_addr (req_addr), .req_wdata (req_wdata),
    .rsp_valid (rsp_valid), .rsp_err (rsp_err), .rsp_rdata (rsp_rdata),
    .reg_en (reg_en), .reg_we (reg_we), .reg_size (reg_size),
    .reg_addr (reg_addr), .reg_wdata (reg_wdata), .reg_rdata (reg_rdata)
  );

  // Register space model: plain big-endian bytes, read data one cycle late.
  always @(posedge clk) begin
    if (rst_n && reg_en) begin
      automatic int nb = 1 << reg_size;
      automatic logic [31:0] v = 32'd0;
      n_acc++;
      if (reg_size != exp_nat) n_szbad++;
      if (reg_we) begin
        n_wr++;
        for (int b = 0; b < nb; b++)
          dm[(int'(reg_addr) + b) % 512] = 8'(reg_wdata >> (8 * (nb - 1 - b)));
      end else begin
        for (int b = 0; b < nb; b++)
          v = (v << 8) | 32'(dm[(int'(reg_addr) + b) % 512]);
        reg_rdata <= v;
      end
    end
  end

  task automatic check(input logic ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // fields: write, size, addr, wdata, exp_err, exp_accesses, exp_cycle
  localparam int NV = 28;
  localparam logic [73:0] VECS [NV] = '{
    {1'b0, 2'd2, 32'h0000_0080, 32'h0,          1'b0, 3'd1, 3'd3}, // R4 long reg
    {1'b1, 2'd2, 32'h0000_0080, 32'h1122_3344,  1'b0, 3'd1, 3'd2}, // R4
    {1'b0, 2'd0, 32'h0000_0081, 32'h0,          1'b0, 3'd1, 3'd3}, // R6
    {1'b1, 2'd0, 32'h0000_0082, 32'h0000_00AB,  1'b0, 3'd2, 3'd4}, // R7
    {1'b0, 2'd2, 32'h0000_0080, 32'h0,          1'b0, 3'd1, 3'd3}, // R7 readback
    {1'b0, 2'd1, 32'h0000_0083, 32'h0,          1'b0, 3'd1, 3'd3}, // R6 low half
    {1'b1, 2'd1, 32'h0000_0080, 32'h0000_CAFE,  1'b0, 3'd2, 3'd4}, // R7 upper half
    {1'b0, 2'd2, 32'h0000_0010, 32'h0,          1'b0, 3'd4, 3'd6}, // R5 byte regs
    {1'b1, 2'd2, 32'h0000_0016, 32'hDEAD_BEEF,  1'b0, 3'd4, 3'd5}, // R5 aligned
    {1'b0, 2'd1, 32'h0000_0016, 32'h0,          1'b0, 3'd2, 3'd4}, // R5
    {1'b1, 2'd1, 32'h0000_0041, 32'h0000_1357,  1'b0, 3'd1, 3'd2}, // R4 word reg
    {1'b0, 2'd0, 32'h0000_0041, 32'h0,          1'b0, 3'd1, 3'd3}, // R6 odd byte
    {1'b1, 2'd0, 32'h0000_0040, 32'h0000_0099,  1'b0, 3'd2, 3'd4}, // R7 even byte
    {1'b0, 2'd2, 32'h0000_0040, 32'h0,          1'b0, 3'd2, 3'd4}, // R5 word regs
    {1'b0, 2'd2, 32'h0000_00C4, 32'h0,          1'b0, 3'd4, 3'd6}, // R3 unassigned
    {1'b1, 2'd2, 32'h0000_0144, 32'h0102_0304,  1'b0, 3'd2, 3'd3}, // R5
    {1'b0, 2'd2, 32'h0000_0144, 32'h0,          1'b0, 3'd2, 3'd4}, // R5
    {1'b0, 2'd1, 32'h0000_01A6, 32'h0,          1'b0, 3'd1, 3'd3}, // R6
    {1'b0, 2'd2, 32'hFFFF_F080, 32'h0,          1'b0, 3'd1, 3'd3}, // R1
    {1'b0, 2'd2, 32'h0000_0200, 32'h0,          1'b1, 3'd0, 3'd1}, // R2
    {1'b1, 2'd0, 32'h0000_03FF, 32'h0000_0077,  1'b1, 3'd0, 3'd1}, // R2
    {1'b0, 2'd3, 32'h0000_0010, 32'h0,          1'b1, 3'd0, 3'd1}, // R2 size 3
    {1'b1, 2'd2, 32'hABCD_E010, 32'hA1B2_C3D4,  1'b0, 3'd4, 3'd5}, // R1
    {1'b0, 2'd0, 32'h0000_0013, 32'h0,          1'b0, 3'd1, 3'd3}, // R4 byte reg
    {1'b1, 2'd1, 32'h0000_01C2, 32'h0000_5AA5,  1'b0, 3'd2, 3'd3}, // R3
    {1'b0, 2'd1, 32'h0000_01C2, 32'h0,          1'b0, 3'd2, 3'd4}, // R3
    {1'b1, 2'd0, 32'h0000_0105, 32'h0000_00E7,  1'b0, 3'd1, 3'd2}, // R4
    {1'b0, 2'd0, 32'h0000_01BF, 32'h0,          1'b0, 3'd1, 3'd3}  // R6 last lane
  };

  task automatic run_vec(input int i);
    logic        w;
    logic [1:0]  sz;
    logic [31:0] ad;
    logic [31:0] wd;
    logic        e_err;
    int          e_acc;
    int          e_cyc;
    logic [9:0]  off;
    logic [1:0]  nat;
    logic        narrow;
    int          sb;
    int          a;
    logic [31:0] e_rd;
    int          acc0;
    int          wr0;
    int          sz0;
    int          cyc;
    int          e_wr;
    string       tag;
    {w, sz, ad, wd, e_err} = VECS[i][73:6];
    e_acc  = int'(VECS[i][5:3]);
    e_cyc  = int'(VECS[i][2:0]);
    off    = ad[9:0];
    nat    = (off[7:6] == 2'b11) ? 2'd0 : off[7:6];
    narrow = (sz < nat);
    sb     = 1 << sz;
    a      = int'(off[8:0]) & ~(sb - 1);
    e_rd   = 32'd0;
    if (!w && !e_err)
      for (int b = 0; b < sb; b++) e_rd = (e_rd << 8) | 32'(rm[a + b]);
    e_wr = (w && !e_err) ? (narrow ? 1 : e_acc) : 0;
    if (e_err)            tag = "R2";
    else if (ad[31:10] != 0) tag = "R1";
    else if (narrow)      tag = w ? "R7" : "R6";
    else if (sz > nat)    tag = "R5";
    else                  tag = "R4";

    @(negedge clk);
    exp_nat   = nat;
    req_valid = 1'b1;
    req_write = w;
    req_size  = sz;
    req_addr  = ad;
    req_wdata = wd;
    acc0 = n_acc; wr0 = n_wr; sz0 = n_szbad;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    cyc = 1;
    check(!req_ready, "R9", "ready low while busy", 32'(req_ready), 32'd0);
    while (!rsp_valid && cyc < 20) begin
      @(negedge clk);
      cyc++;
    end
    check(cyc == e_cyc, "R8", "response cycle", 32'(cyc), 32'(e_cyc));
    check(rsp_err == e_err, tag, "error flag", 32'(rsp_err), 32'(e_err));
    check(rsp_rdata == e_rd, w ? "R9" : tag, "read data", rsp_rdata, e_rd);
    check((n_acc - acc0) == e_acc, (narrow && w) ? "R7" : tag, "access count",
          32'(n_acc - acc0), 32'(e_acc));
    check((n_wr - wr0) == e_wr, (narrow && w) ? "R7" : tag, "write count",
          32'(n_wr - wr0), 32'(e_wr));
    check((n_szbad - sz0) == 0, "R3", "native size of accesses",
          32'(n_szbad - sz0), 32'd0);
    @(negedge clk);
    check(!rsp_valid && req_ready, "R9", "strobe one cycle then ready",
          {30'd0, rsp_valid, req_ready}, 32'd1);
    if (w && !e_err)
      for (int b = 0; b < sb; b++) rm[a + b] = 8'(wd >> (8 * (sb - 1 - b)));
  endtask

  initial begin
    for (int k = 0; k < 512; k++) begin
      dm[k] = 8'(k) ^ 8'h5A;
      rm[k] = 8'(k) ^ 8'h5A;
    end
    repeat (3) @(negedge clk);
    check(req_ready == 1'b1, "R10", "ready in reset", 32'(req_ready), 32'd1);
    check(rsp_valid == 1'b0, "R10", "strobe in reset", 32'(rsp_valid), 32'd0);
    check(reg_en == 1'b0, "R10", "access in reset", 32'(reg_en), 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(req_ready && !reg_en && !rsp_valid, "R10", "idle after reset",
          {29'd0, req_ready, reg_en, rsp_valid}, 32'd4);
    for (int i = 0; i < NV; i++) run_vec(i);
    // corner: idle with no request makes no register access
    begin
      automatic int acc0 = n_acc;
      repeat (5) @(negedge clk);
      check(n_acc == acc0, "R9", "no access while idle", 32'(n_acc - acc0), 32'd0);
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL R8 watchdog: actual 0x1 expected 0x0");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule